// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital controller for a dual-slope integrating analog-to-digital converter. While idle it holds the integrator's shorting switch closed and its counter at zero. A start request begins a conversion. The block captures the sign of the held input and releases the shorting switch. It then routes the held input to the integrator for a fixed run-up interval that it times in clock cycles. After that interval it switches the integrator to a reference whose polarity is opposite to the input sign. It counts clock cycles until the comparator reports that the integrator has returned to zero.

The count is stored in a result register, and a one-cycle done strobe marks each update. On the same clock edge the block returns to idle, which closes the shorting switch again. If the count reaches full scale before the comparator trips, the block stores the all-ones code, raises an overrange flag and returns to idle.

The comparator input is asynchronous and passes through a two-stage synchronizer. The result interface has no back-pressure. The result and the overrange flag stay valid from one done strobe until the next. A consumer that needs the value must capture it on the strobe or before the next conversion ends. The integrator, comparator, sample-and-hold and reference lie outside the block.

Top module: `dsadc_sequencer`

## Requirements
- R1: After reset and whenever the sequencer is idle, `integ_rst_o` is 1 and `sel_ref_o` is 0. The internal counter is zero. Until the first conversion ends, `done_o` is 0 and both `result_o` and `overrange_o` are 0.
- R2: A start request seen while idle makes `integ_rst_o` 0 with `sel_ref_o` 0 (held input routed to the integrator) from the next cycle.
- R3: The run-up phase, during which `integ_rst_o` and `sel_ref_o` are both 0, lasts exactly `RUNUP_CYCLES` clock cycles. After it, `sel_ref_o` becomes 1.
- R4: `ref_pos_o` equals the value of `sign_neg_i` at the accepted start request, where 1 on `ref_pos_o` selects the positive reference for a negative input. It does not change until the conversion ends, whatever `sign_neg_i` does.
- R5: With the default two-stage synchronizer, a comparator that falls during the m-th de-integration cycle, counting from 1, yields `result_o` = m+1. A comparator that is already low when de-integration starts yields 0.
- R6: On the edge that stores a result, `done_o` goes high for exactly one cycle, `integ_rst_o` returns to 1 and `sel_ref_o` to 0. `result_o` does not change between done strobes.
- R7: If the de-integration count reaches 2^RES_W-1 while the synchronized comparator is still high, `result_o` becomes all ones and `overrange_o` becomes 1. A trip on the same cycle that the count reaches 2^RES_W-1 stores all ones with `overrange_o` 0.
- R8: A start request that arrives during run-up or de-integration is ignored. The ongoing conversion keeps its timing and ends with a single done strobe.
- R9: `overrange_o` is updated with every result, so a conversion that trips within range after an overrange clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, honoured only while idle |
| sign_neg_i | input | 1 | 1 when the held input is negative |
| cmp_i | input | 1 | Asynchronous comparator output, high while the integrator is above zero |
| integ_rst_o | output | 1 | Closes the integrator shorting switch (idle) |
| sel_ref_o | output | 1 | 0 routes the held input, 1 routes the reference |
| ref_pos_o | output | 1 | 1 selects the positive reference |
| result_o | output | RES_W | Stored conversion count |
| overrange_o | output | 1 | Last result hit full scale without a trip |
| done_o | output | 1 | One-cycle strobe on each result update |

## Verification
The edges of the count range are the hardest cases to reach from the ports. These are a trip landing exactly on the full-scale count, a count that passes full scale by one, and an integrator that never rises above zero. Each depends on the synchronizer latency and the run-up length adding up precisely. The bench drives the comparator from a behavioural integrator that reacts to the switch outputs. It picks input magnitudes against the reference so that the crossing falls on the chosen de-integration cycle. Start pulses and sign changes are also injected in the middle of conversions.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_RUNUP   = 2'd1,
    PH_RUNDOWN = 2'd2
  } phase_t;

endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/dsadc_counter.sv
module dsadc_counter #(
  parameter int CW          = 8,
  parameter int RUNUP_LEN   = 256,
  parameter int FULL_SCALE  = 255
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o,
  output logic          runup_end_o,
  output logic          full_o
);

  localparam logic [CW-1:0] RUNUP_LAST = CW'(RUNUP_LEN - 1);
  localparam logic [CW-1:0] FULL_VAL   = CW'(FULL_SCALE);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o       = cnt_q;
  assign runup_end_o = (cnt_q == RUNUP_LAST);
  assign full_o      = (cnt_q == FULL_VAL);

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (&cnt_q) |-> clr_i); // R7

endmodule

// File: rtl/dsadc_seq_fsm.sv
module dsadc_seq_fsm
  import dsadc_pkg::*;
#(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             sign_neg_i,
  input  logic             cmp_s_i,
  input  logic             runup_end_i,
  input  logic             full_i,
  input  logic [RES_W-1:0] cnt_i,
  output logic             cnt_clr_o,
  output logic             integ_rst_o,
  output logic             sel_ref_o,
  output logic             ref_pos_o,
  output logic [RES_W-1:0] result_o,
  output logic             over_o,
  output logic             done_o
);

  phase_t           state_q, state_d;
  logic             sign_q;
  logic             prev_q;
  logic             trip, ovf, finish;
  logic [RES_W-1:0] result_q;
  logic             over_q;
  logic             done_q;

  always_comb begin
    trip    = (state_q == PH_RUNDOWN) && prev_q && !cmp_s_i;
    ovf     = (state_q == PH_RUNDOWN) && !trip && full_i;
    finish  = trip || ovf;
    state_d = state_q;
    unique case (state_q)
      PH_IDLE:    if (start_i)     state_d = PH_RUNUP;
      PH_RUNUP:   if (runup_end_i) state_d = PH_RUNDOWN;
      PH_RUNDOWN: if (finish)      state_d = PH_IDLE;
      default:                     state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PH_IDLE;
      sign_q   <= 1'b0;
      prev_q   <= 1'b1;
      result_q <= '0;
      over_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      prev_q  <= (state_q == PH_RUNDOWN) ? cmp_s_i : 1'b1;
      if (state_q == PH_IDLE && start_i) sign_q <= sign_neg_i;
      if (finish) begin
        result_q <= trip ? cnt_i : '1;
        over_q   <= ovf;
      end
    end
  end

  assign cnt_clr_o   = (state_q == PH_IDLE) || (state_q != state_d);
  assign integ_rst_o = (state_q == PH_IDLE);
  assign sel_ref_o   = (state_q == PH_RUNDOWN);
  assign ref_pos_o   = sign_q;
  assign result_o    = result_q;
  assign over_o      = over_q;
  assign done_o      = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R6
  AST_DONE_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == PH_IDLE)); // R6
  AST_OVER_FULLSCALE: assert property (@(posedge clk) disable iff (!rst_n)
    over_q |-> (&result_q)); // R7
  AST_REF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PH_IDLE) |=> (state_q == PH_IDLE || $stable(sign_q))); // R4
  AST_RUNUP_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_RUNUP && !runup_end_i) |=> (state_q == PH_RUNUP)); // R8
  AST_RUNUP_TO_RUNDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_RUNUP && runup_end_i) |=> (state_q == PH_RUNDOWN)); // R3

endmodule

// File: rtl/dsadc_sequencer.sv
module dsadc_sequencer #(
  parameter int RES_W        = 8,
  parameter int RUNUP_CYCLES = 1 << RES_W,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             sign_neg_i,
  input  logic             cmp_i,
  output logic             integ_rst_o,
  output logic             sel_ref_o,
  output logic             ref_pos_o,
  output logic [RES_W-1:0] result_o,
  output logic             overrange_o,
  output logic             done_o
);

  localparam int RUNUP_W    = (RUNUP_CYCLES > 1) ? $clog2(RUNUP_CYCLES) : 1;
  localparam int CW         = (RES_W > RUNUP_W) ? RES_W : RUNUP_W;
  localparam int FULL_SCALE = (1 << RES_W) - 1;

  logic          cmp_s;
  logic [CW-1:0] cnt_q;
  logic          cnt_clr;
  logic          runup_end;
  logic          cnt_full;

  dsadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (cmp_i),
    .sync_o  (cmp_s)
  );

  dsadc_counter #(
    .CW         (CW),
    .RUNUP_LEN  (RUNUP_CYCLES),
    .FULL_SCALE (FULL_SCALE)
  ) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (cnt_clr),
    .cnt_o       (cnt_q),
    .runup_end_o (runup_end),
    .full_o      (cnt_full)
  );

  dsadc_seq_fsm #(.RES_W(RES_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .sign_neg_i  (sign_neg_i),
    .cmp_s_i     (cmp_s),
    .runup_end_i (runup_end),
    .full_i      (cnt_full),
    .cnt_i       (cnt_q[RES_W-1:0]),
    .cnt_clr_o   (cnt_clr),
    .integ_rst_o (integ_rst_o),
    .sel_ref_o   (sel_ref_o),
    .ref_pos_o   (ref_pos_o),
    .result_o    (result_o),
    .over_o      (overrange_o),
    .done_o      (done_o)
  );

  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    integ_rst_o |-> (cnt_q == '0)); // R1
  AST_SWITCH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(integ_rst_o && sel_ref_o)); // R6
  AST_DONE_CLOSES_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (integ_rst_o && $past(sel_ref_o))); // R6

endmodule

// File: tb/dsadc_sequencer_bench.sv
`timescale 1ns/1ps
module dsadc_sequencer_bench;

  localparam int RW   = 8;
  localparam int T1   = 1 << RW;
  localparam int FULL = (1 << RW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          sign_neg_i = 1'b0;
  logic          cmp_i = 1'b0;
  logic          integ_rst_o, sel_ref_o, ref_pos_o, overrange_o, done_o;
  logic [RW-1:0] result_o;

  int n_chk = 0, n_fail = 0, n_done = 0, n_conv = 0, stab_bad = 0;
  int a_mag = 0, a_ref = 1;
  bit ended = 1'b0;
  logic [RW:0] exp_q[$];

  always #2 clk = ~clk;

  dsadc_sequencer #(.RES_W(RW)) u_dsadc_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sign_neg_i(sign_neg_i),
    .cmp_i(cmp_i), .integ_rst_o(integ_rst_o), .sel_ref_o(sel_ref_o),
    .ref_pos_o(ref_pos_o), .result_o(result_o), .overrange_o(overrange_o),
    .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Behavioural integrator and comparator, updated away from the active edge
  initial begin
    int v = 0;
    forever begin
      @(negedge clk);
      if (integ_rst_o)     v = 0;
      else if (!sel_ref_o) v = v + a_mag;
      else                 v = v - a_ref;
      cmp_i = (v > 0);
    end
  end

  // Monitor: pop expected results on each done strobe
  initial begin
    logic [RW-1:0] last = '0;
    forever begin
      @(negedge clk);
      if (done_o) begin
        n_done++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", "unexpected done", 1, 0);
        end else begin
          logic [RW:0] e;
          e = exp_q.pop_front();
          chk(result_o == e[RW-1:0], "R5", "result", int'(result_o), int'(e[RW-1:0]));
          chk(overrange_o == e[RW], "R7", "overrange flag", int'(overrange_o), int'(e[RW]));
        end
        chk(integ_rst_o && !sel_ref_o, "R6", "switch state at done", int'({integ_rst_o, sel_ref_o}), 2);
        last = result_o;
      end else if (rst_n && result_o != last) begin
        stab_bad++;
      end
    end
  end

  task automatic convert(input int mag, input int vr, input bit neg, input bit poke);
    int m, ev, runup, badpol;
    logic [RW:0] e;
    while (!integ_rst_o) @(negedge clk);
    a_mag = mag; a_ref = vr; sign_neg_i = neg;
    m = (T1 * mag + vr - 1) / vr;
    if (mag == 0)         e = {1'b0, RW'(0)};
    else if (m + 1 <= FULL) e = {1'b0, RW'(m + 1)};
    else                  e = {1'b1, RW'(FULL)};
    exp_q.push_back(e);
    n_conv++;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(!integ_rst_o && !sel_ref_o, "R2", "held input routed after start", int'({integ_rst_o, sel_ref_o}), 0);
    runup = 0;
    while (!integ_rst_o && !sel_ref_o) begin
      runup++;
      start_i = poke && (runup == 5);                  // R8 start while busy
      if (poke && runup == 6) sign_neg_i = ~neg;       // R4 sign changes mid-run
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(runup == T1, "R3", "run-up length", runup, T1);
    badpol = 0;
    while (sel_ref_o) begin
      if (ref_pos_o != neg) badpol++;
      start_i = poke && (badpol == 0);
      @(negedge clk);
      start_i = 1'b0;
    end
    chk(badpol == 0, "R4", "reference polarity cycles wrong", badpol, 0);
    sign_neg_i = neg;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(integ_rst_o && !sel_ref_o && !done_o, "R1", "idle switches in reset", int'({integ_rst_o, sel_ref_o, done_o}), 4);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(integ_rst_o && !sel_ref_o, "R1", "idle switches after reset", int'({integ_rst_o, sel_ref_o}), 2);
    chk(result_o == '0 && !overrange_o && !done_o, "R1", "result idle", int'(result_o), 0);

    convert(10, 256, 1'b0, 1'b0);   // R5 small positive input
    convert(37, 100, 1'b1, 1'b0);   // R5 non-integer ratio, negative input
    convert(0, 256, 1'b0, 1'b0);    // R5 comparator never high
    convert(254, 256, 1'b0, 1'b0);  // R7 trip on full-scale count
    convert(255, 256, 1'b1, 1'b0);  // R7 overrange
    convert(3, 256, 1'b0, 1'b1);    // R9 clears flag, R8 start ignored, R4 sign change
    convert(1, 300, 1'b1, 1'b0);    // R5 single de-integration step
    convert(120, 128, 1'b1, 1'b1);  // R5 larger count with busy starts

    repeat (4) @(negedge clk);
    chk(n_done == n_conv, "R8", "done strobes per conversion", n_done, n_conv);
    chk(exp_q.size() == 0, "R6", "results outstanding", exp_q.size(), 0);
    chk(stab_bad == 0, "R6", "result changes between strobes", stab_bad, 0);
    chk(integ_rst_o && !sel_ref_o, "R1", "idle after last conversion", int'({integ_rst_o, sel_ref_o}), 2);
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule